// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Timer

This block raises a cartridge interrupt from an 8-bit up-counter. Once armed, the counter advances in one of two ways. In cycle mode it advances on every CPU cycle. In scanline mode a signed prescaler counts down by 3 on each CPU cycle, which models three picture dots per CPU cycle. When the prescaler reaches zero or goes below it, 341 is added back and the counter advances by one. That gives about one count per 341-dot video line.

When the counter advances from 0xFF, it reloads from a programmable reload value and latches a pending flag. The interrupt line is the pending flag gated by the enable flag.

Software drives the block through a small write port. The address has already been decoded upstream into a 2-bit register select, so the block only sees the select and the data byte. A static strap input marks whether the timer is fitted at all. When the strap is low, the block is inert. The clock is the system clock, and a one-cycle `cpuTick` strobe marks each CPU cycle.

Top module: `scanIrqTimer`

## Requirements
- R1: After reset the interrupt output is low, and the counter, reload value, prescaler, mode, auto-re-enable, enable and pending state are all zero.
- R2: A write with select 0 loads data bits [3:0] into the low four bits of the reload value. A write with select 1 loads data bits [3:0] into the high four bits. Data bits [7:4] are ignored in both cases.
- R3: A write with select 2 sets three fields: data bit 2 selects the mode (1 = cycle mode, 0 = scanline mode), data bit 0 sets auto-re-enable, and data bit 1 sets enable. When data bit 1 is 1, the counter is loaded from the reload value and the prescaler is set to 341. Every select-2 write clears the pending flag.
- R4: A write with select 3 clears the pending flag and copies the auto-re-enable bit into the enable flag.
- R5: Each counter clock adds one to the counter. If the counter is 0xFF, the clock instead reloads the counter from the reload value and sets the pending flag, and the interrupt output goes high after that same clock edge.
- R6: In cycle mode, every `cpuTick` cycle while enabled clocks the counter.
- R7: In scanline mode, every `cpuTick` cycle while enabled subtracts 3 from the prescaler. When the result is zero or less, 341 is added to it and the counter is clocked once. Starting from a load, the first three counter clocks therefore come after 114, 114 and 113 ticks.
- R8: While the enable flag is clear, neither the prescaler nor the counter changes.
- R9: The interrupt output equals the pending flag AND the enable flag, and holds across cycles with no `cpuTick`.
- R10: In a cycle where a write is accepted, any `cpuTick` in that cycle is dropped. The prescaler and counter do not advance on that tick.
- R11: While `timerFitted` is low, all writes are ignored and neither the prescaler nor the counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuTick | input | 1 | One-cycle strobe per CPU cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 reload low, 1 reload high, 2 control, 3 acknowledge |
| wrData | input | 8 | Write data |
| timerFitted | input | 1 | Strap: 1 = timer present, 0 = inert |
| irqOut | output | 1 | Interrupt request, pending AND enable |

## Verification
Only `irqOut` reveals internal state, so each fault has to be caught at the next wrap. A wrong counter value or reload nibble moves the rising edge of `irqOut` earlier or later by a whole number of counter clocks. In cycle mode that shows up within 256 ticks. A prescaler error shows as an interval that differs from the 114/114/113 tick pattern, so the bench times several consecutive scanline wraps after a single load. A fault in the enable, acknowledge or strap handling shows up within one cycle of the write as a wrong level on `irqOut`. It also shows up at the next expected rise, either as a rise that should not happen or as a rise that is missing.

// File: rtl/scanIrqPkg.sv
package scanIrqPkg;

  // Register select codes after upstream address decode.
  localparam logic [1:0] SEL_RELOAD_LO = 2'd0;
  localparam logic [1:0] SEL_RELOAD_HI = 2'd1;
  localparam logic [1:0] SEL_CONTROL   = 2'd2;
  localparam logic [1:0] SEL_ACK       = 2'd3;

  // Control byte bit positions.
  localparam int CTL_AUTO_BIT = 0;
  localparam int CTL_EN_BIT   = 1;
  localparam int CTL_MODE_BIT = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadCnt;    // arm: counter <= reload, prescaler <= line length
    logic advance;    // one accepted CPU cycle while enabled
    logic cycleMode;  // 1: clock counter per CPU cycle
  } dpCmdT;

endpackage

// File: rtl/scanIrqCtrl.sv
module scanIrqCtrl
  import scanIrqPkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTick,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerFitted,
  input  logic              wrapPulse,
  output dpCmdT             dpCmd,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              irqOut
);

  localparam int HALF_W = CNT_W / 2;

  logic             wrOk;
  logic [CNT_W-1:0] reloadQ;
  logic             modeQ;
  logic             autoQ;
  logic             enableQ;
  logic             pendQ;

  assign wrOk = wrEn & timerFitted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
      modeQ   <= 1'b0;
      autoQ   <= 1'b0;
      enableQ <= 1'b0;
      pendQ   <= 1'b0;
    end else if (wrOk) begin
      unique case (wrSel)
        SEL_RELOAD_LO: reloadQ[HALF_W-1:0]     <= wrData[HALF_W-1:0];
        SEL_RELOAD_HI: reloadQ[CNT_W-1:HALF_W] <= wrData[CNT_W-HALF_W-1:0];
        SEL_CONTROL: begin
          modeQ   <= wrData[CTL_MODE_BIT];
          autoQ   <= wrData[CTL_AUTO_BIT];
          enableQ <= wrData[CTL_EN_BIT];
          pendQ   <= 1'b0;
        end
        default: begin
          pendQ   <= 1'b0;
          enableQ <= autoQ;
        end
      endcase
    end else if (wrapPulse) begin
      pendQ <= 1'b1;
    end
  end

  always_comb begin
    dpCmd.loadCnt   = wrOk && (wrSel == SEL_CONTROL) && wrData[CTL_EN_BIT];
    dpCmd.advance   = timerFitted && cpuTick && enableQ && !wrEn;
    dpCmd.cycleMode = modeQ;
  end

  assign reloadVal = reloadQ;
  assign irqOut    = pendQ & enableQ;

endmodule

// File: rtl/scanIrqDatapath.sv
module scanIrqDatapath
  import scanIrqPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LINE_DOTS = 341,
  parameter int DOT_STEP  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmdT            dpCmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             wrapPulse,
  output logic [CNT_W-1:0] cntVal
);

  localparam int PRE_W = $clog2(LINE_DOTS + 1) + 1;
  localparam logic signed [PRE_W-1:0] LINE_S = PRE_W'(LINE_DOTS);
  localparam logic signed [PRE_W-1:0] STEP_S = PRE_W'(DOT_STEP);

  logic signed [PRE_W-1:0] preQ;
  logic signed [PRE_W-1:0] preDec;
  logic                    lineDone;
  logic                    cntClock;
  logic [CNT_W-1:0]        cntQ;

  always_comb begin
    preDec    = preQ - STEP_S;
    lineDone  = preDec[PRE_W-1] || (preDec == '0);
    cntClock  = dpCmd.advance && (dpCmd.cycleMode || lineDone);
    wrapPulse = cntClock && (&cntQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (dpCmd.loadCnt) begin
      preQ <= LINE_S;
      cntQ <= reloadVal;
    end else if (dpCmd.advance) begin
      if (!dpCmd.cycleMode) begin
        preQ <= lineDone ? preDec + LINE_S : preDec;
      end
      if (cntClock) begin
        cntQ <= wrapPulse ? reloadVal : cntQ + 1'b1;
      end
    end
  end

  assign cntVal = cntQ;

endmodule

// File: rtl/scanIrqTimer.sv
module scanIrqTimer
  import scanIrqPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 8,
  parameter int LINE_DOTS = 341,
  parameter int DOT_STEP  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTick,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerFitted,
  output logic              irqOut
);

  dpCmdT            dpCmd;
  logic             wrapPulse;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cntVal;

  scanIrqCtrl #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuTick    (cpuTick),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .timerFitted(timerFitted),
    .wrapPulse  (wrapPulse),
    .dpCmd      (dpCmd),
    .reloadVal  (reloadVal),
    .irqOut     (irqOut)
  );

  scanIrqDatapath #(
    .CNT_W    (CNT_W),
    .LINE_DOTS(LINE_DOTS),
    .DOT_STEP (DOT_STEP)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCmd    (dpCmd),
    .reloadVal(reloadVal),
    .wrapPulse(wrapPulse),
    .cntVal   (cntVal)
  );

endmodule

// File: rtl/scanIrqChecker.sv
module scanIrqChecker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuTick,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              timerFitted,
  input logic              irqOut,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  reloadVal
);

  AST_CTRL_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && timerFitted && wrSel == 2'd2) |=> !irqOut); // R3

  AST_ARM_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && timerFitted && wrSel == 2'd2 && wrData[1]) |=> (cntVal == $past(reloadVal))); // R3

  AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && timerFitted && wrSel == 2'd3) |=> !irqOut); // R4

  AST_RISE_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(cpuTick)); // R5

  AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && timerFitted && wrSel != 2'd2) |=> (cntVal == $past(cntVal))); // R10

  AST_INERT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !timerFitted |=> (irqOut == $past(irqOut) && cntVal == $past(cntVal))); // R11

endmodule

bind scanIrqTimer scanIrqChecker #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuTick    (cpuTick),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .timerFitted(timerFitted),
  .irqOut     (irqOut),
  .cntVal     (cntVal),
  .reloadVal  (reloadVal)
);

// File: tb/sim_scanIrqTimer.sv
`timescale 1ns/1ps
module sim_scanIrqTimer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       timerFitted = 1'b1;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  logic [7:0] mRel, mCnt;
  int         mPre;
  logic       mMode, mAuto, mEn, mPend;

  always #2.5 clk = ~clk;

  scanIrqTimer u0 (
    .clk(clk), .rstN(rstN), .cpuTick(cpuTick), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .timerFitted(timerFitted), .irqOut(irqOut)
  );

  function automatic void modelReset();
    mRel = 8'h00; mCnt = 8'h00; mPre = 0;
    mMode = 1'b0; mAuto = 1'b0; mEn = 1'b0; mPend = 1'b0;
  endfunction

  function automatic void modelStep(input logic we, input logic [1:0] sel,
                                    input logic [7:0] d, input logic tk, input logic fit);
    logic clkCnt;
    if (!fit) return;
    if (we) begin
      case (sel)
        2'd0: mRel[3:0] = d[3:0];
        2'd1: mRel[7:4] = d[3:0];
        2'd2: begin
          mMode = d[2]; mAuto = d[0]; mEn = d[1]; mPend = 1'b0;
          if (d[1]) begin mCnt = mRel; mPre = 341; end
        end
        default: begin mPend = 1'b0; mEn = mAuto; end
      endcase
    end else if (tk && mEn) begin
      clkCnt = mMode;
      if (!mMode) begin
        mPre = mPre - 3;
        if (mPre <= 0) begin mPre = mPre + 341; clkCnt = 1'b1; end
      end
      if (clkCnt) begin
        if (mCnt == 8'hFF) begin mCnt = mRel; mPend = 1'b1; end
        else mCnt = mCnt + 8'd1;
      end
    end
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irqOut actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d,
                     input logic tk, input logic fit);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; cpuTick = tk; timerFitted = fit;
    @(posedge clk);
    modelStep(we, sel, d, tk, fit);
    #1;
    check(irqOut, mPend & mEn, "R9");
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cyc(1'b1, sel, d, 1'b0, 1'b1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    modelReset();
    repeat (3) @(posedge clk);
    #1 check(irqOut, 1'b0, "R1");
    @(negedge clk) rstN = 1'b1;

    // R1: reload cleared by reset -> counter armed at 0, wraps after 256 ticks.
    wr(2'd2, 8'h06);
    ticks(255);
    check(irqOut, 1'b0, "R1");
    ticks(1);
    check(irqOut, 1'b1, "R5");

    // R2: nibble writes, high data bits ignored -> reload 0xFD.
    wr(2'd0, 8'hAD);
    wr(2'd1, 8'h5F);
    wr(2'd2, 8'h06);
    check(irqOut, 1'b0, "R3");
    ticks(2);
    check(irqOut, 1'b0, "R2");
    ticks(1);
    check(irqOut, 1'b1, "R6");
    repeat (4) cyc(1'b0, 2'd0, 8'd0, 1'b0, 1'b1);
    check(irqOut, 1'b1, "R9");

    // R4/R8: acknowledge with auto=0 disables; ticks then do nothing.
    wr(2'd3, 8'h00);
    check(irqOut, 1'b0, "R4");
    ticks(300);
    check(irqOut, 1'b0, "R8");

    // R4: auto=1 keeps counting after acknowledge.
    wr(2'd2, 8'h07);
    ticks(3);
    check(irqOut, 1'b1, "R6");
    wr(2'd3, 8'h00);
    check(irqOut, 1'b0, "R4");
    ticks(2);
    check(irqOut, 1'b0, "R4");
    ticks(1);
    check(irqOut, 1'b1, "R4");

    // R10: writes with simultaneous ticks drop those ticks.
    wr(2'd2, 8'h06);
    repeat (3) cyc(1'b1, 2'd0, 8'h0D, 1'b1, 1'b1);
    ticks(2);
    check(irqOut, 1'b0, "R10");
    ticks(1);
    check(irqOut, 1'b1, "R10");

    // R7: scanline mode, reload 0xFF -> wraps at 114, 114, 113 ticks.
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h03);
    ticks(113);
    check(irqOut, 1'b0, "R7");
    ticks(1);
    check(irqOut, 1'b1, "R7");
    wr(2'd3, 8'h00);
    ticks(113);
    check(irqOut, 1'b0, "R7");
    ticks(1);
    check(irqOut, 1'b1, "R7");
    wr(2'd3, 8'h00);
    ticks(112);
    check(irqOut, 1'b0, "R7");
    ticks(1);
    check(irqOut, 1'b1, "R7");

    // R11: inert strap ignores writes and freezes counting.
    cyc(1'b1, 2'd3, 8'h00, 1'b0, 1'b0);
    check(irqOut, 1'b1, "R11");
    cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    check(irqOut, 1'b1, "R11");
    wr(2'd2, 8'h06);
    repeat (5) cyc(1'b0, 2'd0, 8'd0, 1'b1, 1'b0);
    check(irqOut, 1'b0, "R11");
    ticks(1);
    check(irqOut, 1'b1, "R11");

    // Random phase against the reference state.
    for (int i = 0; i < 4000; i++) begin
      logic we, tk, fit;
      we  = ($urandom % 8) == 0;
      tk  = ($urandom % 2) == 0;
      fit = ($urandom % 16) != 0;
      cyc(we, 2'($urandom % 4), 8'($urandom), tk, fit);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule